// File: doc/BRIEF.md
# Three-wire serial EEPROM device engine

This block is the device side of a three-wire serial memory that holds 64 words of 16 bits. A host selects it with a select line, clocks it with a shift clock and feeds it serial data. The select, shift clock and data lines are brought into the system clock domain by a synchronizer. The data line is sampled on each rising shift-clock edge. Each frame begins with a start bit, followed by a two-bit command code and six address bits. From these the engine serves word reads, single-word writes and erases, whole-array writes and erases, and commands that arm or disarm programming.

Programming is guarded by a sticky enable flag that is cleared at reset. Every store starts a self-timed program cycle of `PROG_CYCLES` system clocks, and the engine accepts no command while that cycle runs. If the host drops and re-raises the select line during the cycle, the serial output reports busy or ready. The output has a separate enable, `do_oe_o`. The output is high impedance whenever that enable is low.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After the select line goes high, the first 1 sampled on a rising shift-clock edge is the start bit; zeros before it are skipped. It is followed by a two-bit code and then six address bits, each sent MSB first.
- R2: Code 10 is a read. Starting from the rising edge that carries the last address bit, the output presents one dummy 0. On each following rising edge it presents the next of the 16 data bits, MSB first. A read works whether or not programming is enabled.
- R3: Code 01 is followed by 16 data bits, MSB first, and stores them in the addressed word. The word need not be erased first.
- R4: Code 11 sets every bit of the addressed word to 1 and leaves other words unchanged.
- R5: Code 00 is decoded by the two top address bits; the four low address bits are ignored. Top bits 11 enable programming and 00 disable it. After reset, programming is disabled, and the flag keeps its value until the next such command.
- R6: Code 00 with top address bits 10 sets every word to all ones. With top bits 01, the 16 data bits that follow are stored in every word.
- R7: A write, erase, whole-array write or whole-array erase received while programming is disabled leaves the memory unchanged.
- R8: Each store starts a program cycle lasting `PROG_CYCLES` system clocks. For a write it starts after the last data bit; for an erase it starts once the address is decoded. A command received during the cycle is ignored.
- R9: If the select line is lowered and raised again during a program cycle, the output is enabled and reads 0 while busy and 1 once the cycle has ended. If the select line is raised only after the cycle has ended, the output stays disabled.
- R10: `do_oe_o` is 0 while the select line is low. It is also 0 whenever neither read data nor status is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Device select, active high, asynchronous |
| sk_i | input | 1 | Serial shift clock, asynchronous |
| di_i | input | 1 | Serial data from host |
| do_o | output | 1 | Serial data or ready/busy status to host |
| do_oe_o | output | 1 | Output enable for do_o; 0 means high impedance |

## Verification
A shift-clock edge acts inside the engine about three system clocks after the bench raises it: two synchronizer stages plus one edge register. Read data appears one clock after that, so the bench samples each output bit eight clocks after the rising edge, just before the next one. Status is sampled six clocks after the select line rises. The program-cycle length is checked twice: busy is expected 30 clocks before the nominal end and ready 40 clocks after it, which leaves margin for the synchronizer delay in both directions. Every read is pushed as an expected 17-bit item (dummy plus word) into a scoreboard queue, and a monitor pops it against the captured bits.

// File: rtl/mw_pkg.sv
package mw_pkg;
  // command code carried in the two bits after the start bit
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  // sub-command selected by the top two address bits under OP_EXT
  typedef enum logic [1:0] {
    EXT_LOCK   = 2'b00,
    EXT_FILL   = 2'b01,
    EXT_CLEAR  = 2'b10,
    EXT_UNLOCK = 2'b11
  } mw_ext_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HUNT,
    ST_STATUS,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_LOAD,
    ST_READ,
    ST_DONE
  } mw_state_e;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_ONE,
    WR_ALL
  } mw_wr_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], async_i[b]};
    end else begin : g_single
      always_comb chain_d = async_i[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)             cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  // R8: the engine never launches a store while one is running
  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);

  // R8: a running cycle only counts down by one per clock
  p_countdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mw_wr_e            wr_kind_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if ((wr_kind_i == WR_ALL) ||
          ((wr_kind_i == WR_ONE) && (wr_addr_i == ADDR_W'(i))))
        mem_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R6: a whole-array store reaches the first and the last word
  p_fill_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind_i == WR_ALL) |=>
      ((mem_q[0] == $past(wr_data_i)) && (mem_q[DEPTH-1] == $past(wr_data_i))));
endmodule

// File: rtl/mw_proto.sv
module mw_proto
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output mw_wr_e            wr_kind_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              start_o,
  output logic              do_o,
  output logic              do_oe_o
);
  localparam int CNT_MAX = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  mw_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-2:0] data_q, data_d;
  logic [DATA_W:0]   shr_q, shr_d;
  logic              en_q, en_d;
  logic              sk_prev_q;
  logic              sk_rise;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] data_n;
  mw_ext_e           ext_sel;

  assign sk_rise = sk_i && !sk_prev_q;
  assign addr_n  = {addr_q[ADDR_W-2:0], di_i};
  assign data_n  = {data_q, di_i};
  assign ext_sel = mw_ext_e'(addr_n[ADDR_W-1 -: 2]);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    op_d      = op_q;
    addr_d    = addr_q;
    data_d    = data_q;
    shr_d     = shr_q;
    en_d      = en_q;
    wr_kind_o = WR_NONE;
    wr_addr_o = addr_q;
    wr_data_o = '1;
    start_o   = 1'b0;

    if (!cs_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = busy_i ? ST_STATUS : ST_HUNT;
        ST_HUNT, ST_STATUS: begin
          if (sk_rise && di_i) begin
            state_d = ST_OPC;
            cnt_d   = '0;
          end
        end
        ST_OPC: begin
          if (sk_rise) begin
            op_d  = {op_q[0], di_i};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(1)) begin
              state_d = ST_ADDR;
              cnt_d   = '0;
            end
          end
        end
        ST_ADDR: begin
          if (sk_rise) begin
            addr_d = addr_n;
            cnt_d  = cnt_q + 1'b1;
            if (cnt_q == ADDR_LAST) begin
              cnt_d   = '0;
              state_d = ST_DONE;
              if (!busy_i) begin
                unique case (mw_op_e'(op_q))
                  OP_READ:  state_d = ST_LOAD;
                  OP_WRITE: if (en_q) state_d = ST_DATA;
                  OP_ERASE: begin
                    if (en_q) begin
                      wr_kind_o = WR_ONE;
                      wr_addr_o = addr_n;
                      start_o   = 1'b1;
                    end
                  end
                  OP_EXT: begin
                    unique case (ext_sel)
                      EXT_UNLOCK: en_d = 1'b1;
                      EXT_LOCK:   en_d = 1'b0;
                      EXT_CLEAR: begin
                        if (en_q) begin
                          wr_kind_o = WR_ALL;
                          start_o   = 1'b1;
                        end
                      end
                      EXT_FILL: if (en_q) state_d = ST_DATA;
                      default: ;
                    endcase
                  end
                  default: ;
                endcase
              end
            end
          end
        end
        ST_DATA: begin
          if (sk_rise) begin
            data_d = data_n[DATA_W-2:0];
            cnt_d  = cnt_q + 1'b1;
            if (cnt_q == DATA_LAST) begin
              state_d = ST_DONE;
              cnt_d   = '0;
              if (!busy_i) begin
                wr_kind_o = (mw_op_e'(op_q) == OP_WRITE) ? WR_ONE : WR_ALL;
                wr_data_o = data_n;
                start_o   = 1'b1;
              end
            end
          end
        end
        ST_LOAD: begin
          shr_d   = {1'b0, rd_data_i};
          state_d = ST_READ;
        end
        ST_READ: begin
          if (sk_rise) shr_d = {shr_q[DATA_W-1:0], 1'b0};
        end
        ST_DONE: ;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      op_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      shr_q     <= '0;
      en_q      <= 1'b0;
      sk_prev_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      op_q      <= op_d;
      addr_q    <= addr_d;
      data_q    <= data_d;
      shr_q     <= shr_d;
      en_q      <= en_d;
      sk_prev_q <= sk_i;
    end
  end

  assign rd_addr_o = addr_q;
  assign do_oe_o   = (state_q == ST_READ) || (state_q == ST_STATUS);
  assign do_o      = (state_q == ST_READ) ? shr_q[DATA_W] : !busy_i;

  // R10: output released one clock after the synchronized select drops
  p_hiz_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> !do_oe_o);

  // R2: the first presented read bit is the dummy zero
  p_dummy_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD) |=> (do_oe_o && !do_o));

  // R5: the enable flag only moves right after a sampled shift-clock edge
  p_enable_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $past(sk_rise));

  // R7: no store is issued while programming is disabled
  p_prog_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind_o != WR_NONE) |-> en_q);
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [2:0]        pins_sync;
  logic              busy;
  logic              start;
  mw_wr_e            wr_kind;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  mw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({cs_i, sk_i, di_i}),
    .sync_o  (pins_sync)
  );

  mw_proto #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_proto (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_i      (pins_sync[2]),
    .sk_i      (pins_sync[1]),
    .di_i      (pins_sync[0]),
    .busy_i    (busy),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_kind_o (wr_kind),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .start_o   (start),
    .do_o      (do_o),
    .do_oe_o   (do_oe_o)
  );

  mw_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start),
    .busy_o  (busy)
  );

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_kind_i (wr_kind),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );
endmodule

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int PC = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  wire  do_w;
  wire  oe_w;

  always #10 clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_oe_o(oe_w)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem [64];
  logic [DW:0] exp_q [$];
  string       tag_q [$];
  logic [DW:0] obs_q [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic v, output logic so);
    di = v;
    clk_n(4);
    so = do_w;
    sk = 1'b1;
    clk_n(4);
    sk = 1'b0;
  endtask

  task automatic send_bit(input logic v);
    logic dummy;
    bit_cycle(v, dummy);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
    send_bit(1'b1);
    send_bit(op[1]);
    send_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic send_word(input logic [DW-1:0] w);
    for (int i = DW - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic cs_on();
    cs = 1'b1;
    clk_n(6);
  endtask

  task automatic cs_off();
    di = 1'b0;
    cs = 1'b0;
    clk_n(6);
  endtask

  // scoreboard driver: queue the expected dummy+word, capture the real one
  task automatic do_read(input logic [AW-1:0] a, input string tag);
    logic [DW:0] w;
    logic b;
    cs_on();
    send_hdr(2'b10, a);
    exp_q.push_back({1'b0, ref_mem[a]});
    tag_q.push_back(tag);
    w = '0;
    for (int i = 0; i <= DW; i++) begin
      bit_cycle(1'b0, b);
      w = {w[DW-1:0], b};
    end
    obs_q.push_back(w);
    cs_off();
  endtask

  task automatic prog_cmd(input logic [1:0] op, input logic [AW-1:0] a);
    cs_on();
    send_hdr(op, a);
    cs_off();
    clk_n(PC + 20);
  endtask

  task automatic prog_data(input logic [1:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] w);
    cs_on();
    send_hdr(op, a);
    send_word(w);
    cs_off();
    clk_n(PC + 20);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (obs_q.size() > 0);
      check(tag_q.pop_front(), 32'(obs_q.pop_front()), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    clk_n(150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clk_n(5);
    rst_n = 1'b1;
    clk_n(10);
    check("R10 reset output disabled", 32'(oe_w), 32'd0);

    // R5: enable programming, ext code with top bits 11 and junk low bits
    prog_cmd(2'b00, 6'b110101);

    // R1: leading zeros before the start bit are skipped
    cs_on();
    send_bit(1'b0);
    send_bit(1'b0);
    send_hdr(2'b01, 6'd5);
    send_word(16'hA55A);
    cs_off();
    clk_n(PC + 20);
    ref_mem[5] = 16'hA55A;
    do_read(6'd5, "R1 R3 write after leading zeros");

    prog_data(2'b01, 6'd63, 16'h1234);
    ref_mem[63] = 16'h1234;
    do_read(6'd63, "R3 write top address");

    // R3: overwrite without erase, bits go both ways
    prog_data(2'b01, 6'd5, 16'h5AA5);
    ref_mem[5] = 16'h5AA5;
    do_read(6'd5, "R3 overwrite without erase");

    // R4: erase one word
    prog_cmd(2'b11, 6'd5);
    ref_mem[5] = 16'hFFFF;
    do_read(6'd5, "R4 erased word all ones");
    do_read(6'd63, "R4 neighbour untouched");

    // R10: selected but idle, output stays disabled
    cs_on();
    check("R10 idle select output disabled", 32'(oe_w), 32'd0);
    cs_off();

    // R6: whole-array write
    prog_data(2'b00, 6'b010000, 16'hC3C3);
    for (int i = 0; i < 64; i++) ref_mem[i] = 16'hC3C3;
    do_read(6'd0, "R6 fill word 0");
    do_read(6'd37, "R6 fill word 37");
    do_read(6'd63, "R6 fill word 63");

    // R6: whole-array erase
    prog_cmd(2'b00, 6'b101010);
    for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
    do_read(6'd0, "R6 clear word 0");
    do_read(6'd63, "R6 clear word 63");
    prog_data(2'b01, 6'd10, 16'h0001);
    ref_mem[10] = 16'h0001;

    // R5: disable, then R7 stores ignored, R2 read still works
    prog_cmd(2'b00, 6'b001111);
    prog_data(2'b01, 6'd10, 16'hBEEF);
    do_read(6'd10, "R2 R7 write ignored when disabled");
    prog_cmd(2'b11, 6'd10);
    do_read(6'd10, "R7 erase ignored when disabled");
    prog_data(2'b00, 6'b010000, 16'h0000);
    do_read(6'd10, "R7 fill ignored when disabled");

    // R9 and R8: status during the cycle and cycle length
    prog_cmd(2'b00, 6'b110000);
    cs_on();
    send_hdr(2'b01, 6'd20);
    send_word(16'h1357);
    ref_mem[20] = 16'h1357;
    cs_off();
    cs_on();
    check("R9 status enabled while busy", 32'(oe_w), 32'd1);
    check("R9 status reads busy", 32'(do_w), 32'd0);
    clk_n(PC - 30 - 16);
    check("R8 still busy near cycle end", 32'(do_w), 32'd0);
    clk_n(70);
    check("R8 ready after cycle length", 32'(do_w), 32'd1);
    check("R9 status still enabled when ready", 32'(oe_w), 32'd1);
    cs_off();
    do_read(6'd20, "R3 status-polled write");

    // R9: select raised only after the cycle ended, no status
    cs_on();
    send_hdr(2'b01, 6'd21);
    send_word(16'h2468);
    ref_mem[21] = 16'h2468;
    cs_off();
    clk_n(PC + 20);
    cs_on();
    check("R9 no status after cycle end", 32'(oe_w), 32'd0);
    cs_off();

    // R8: command during a running cycle is ignored
    cs_on();
    send_hdr(2'b01, 6'd30);
    send_word(16'h1111);
    ref_mem[30] = 16'h1111;
    cs_off();
    cs_on();
    send_hdr(2'b01, 6'd31);
    send_word(16'h2222);
    cs_off();
    clk_n(PC + 20);
    do_read(6'd31, "R8 write during busy ignored");
    do_read(6'd30, "R8 first write kept");

    wait (obs_q.size() == 0);
    clk_n(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule